// File: doc/BRIEF.md
# Serial Host Register Access Port

This block is a serial slave that lets a host processor read and write a bank of 8-bit configuration registers over four wires. The host drops an active-low select, clocks in a command byte on the serial input, and then either clocks in one data byte (write) or clocks out the addressed register's byte on the serial output (read). All serial bytes move least significant bit first. The register contents are presented in parallel on a flat output bus so that the surrounding logic can use them directly.

The serial pins are brought into the system clock domain through synchronizers. Serial clock edges are detected there, so the serial clock must run at least four times slower than the system clock. The serial output is split into a data bit and an output enable for the pad ring. The enable is high only while read data is being shifted out, which lets the host tie the serial input and output together. A select input picks whether read data is valid at the rising or at the falling serial clock edge. A write to register address 10 returns every register to its default value and restarts the controller. A write to any other address stores the byte.

Top module: `serial_host_port`

## Requirements
- R1: After reset, register i holds (RST_BASE + i) modulo 256, and the output enable is low.
- R2: The command byte is the first 8 bits after select goes low. Its bit 0 (first on the wire) is the direction (1 = read, 0 = write). Bits 1 to 5 form the 5-bit register address. Bits 6 and 7 are ignored.
- R3: On a write, the 8 bits after the command byte are sampled on rising serial clock edges, LSB first. They are stored into the addressed register after the eighth of those bits.
- R4: With the edge select high, read data bit k (LSB first) is on the data output at rising serial clock edge 9+k, for k = 0 to 7.
- R5: With the edge select low, read data bit k is on the data output at the falling edge that follows rising edge 9+k.
- R6: The output enable is low during the command byte. It is high for the whole read data phase and low again once the last read bit has been presented.
- R7: While select is high, serial clock and data activity changes no register and no controller state.
- R8: If select rises before a transfer is complete, a partial write is discarded and the output enable drops.
- R9: A completed write to address 10 sets every register to its reset value, whatever the data byte.
- R10: After a complete read or write, further serial clocks are ignored until select goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low transfer select from host |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| clkeSel | input | 1 | Read data edge select: 1 rising, 0 falling |
| sdoData | output | 1 | Serial read data bit for the pad |
| sdoOe | output | 1 | Output enable for the serial data pad |
| cfgRegs | output | NUM_REGS*8 | All registers, register i at bits [8i+7:8i] |

## Verification
The bench builds the block with its default parameters: 32 registers, a 5-bit address, soft reset at address 10, reset base 0x40 and two synchronizer stages. With 32 registers the 5-bit address space is full, so the first and last registers and the command bits that are ignored can all be tested. The distinct reset value of each register shows whether a soft reset or a stray write touched the wrong entry. The serial clock half period is five system cycles. This sits close to the minimum ratio, so a read bit that arrives late under either edge select shows up as a wrong sampled bit.

// File: rtl/serport_pkg.sv
package serport_pkg;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_WDATA = 2'd1,
    ST_RDATA = 2'd2,
    ST_HOLD  = 2'd3
  } port_state_t;

  // Control-to-datapath strobes, one system cycle wide
  typedef struct packed {
    logic shiftIn;   // take one SDI bit into the receive shifter
    logic latchCmd;  // command byte complete: latch address, load read data
    logic advOut;    // present next read bit
    logic commit;    // write data byte complete
  } strobe_t;

endpackage

// File: rtl/serport_sync.sv
module serport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdi,
  output logic csActive,
  output logic sdiS,
  output logic sclkRise,
  output logic sclkFall
);
  localparam logic [2:0] IDLE_VAL = 3'b100; // {csN, sclk, sdi}

  logic [STAGES-1:0][2:0] pipe;
  logic [2:0] synced;
  logic       sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe     <= {STAGES{IDLE_VAL}};
      sclkPrev <= 1'b0;
    end else begin
      pipe     <= {pipe[STAGES-2:0], {csN, sclk, sdi}};
      sclkPrev <= synced[1];
    end
  end

  assign synced   = pipe[STAGES-1];
  assign csActive = ~synced[2];
  assign sdiS     = synced[0];
  assign sclkRise = synced[1] & ~sclkPrev;
  assign sclkFall = ~synced[1] & sclkPrev;
endmodule

// File: rtl/serport_ctrl.sv
module serport_ctrl
  import serport_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    csActive,
  input  logic    sclkRise,
  input  logic    sclkFall,
  input  logic    clkeSel,
  input  logic    cmdRead,
  output strobe_t stb,
  output logic    sdoOe
);
  port_state_t state;
  logic [2:0]  bitCnt;
  logic        seenRise;
  logic        lastBit;

  assign lastBit = (bitCnt == 3'd7);

  always_comb begin
    stb = '0;
    if (csActive) begin
      unique case (state)
        ST_CMD: begin
          stb.shiftIn  = sclkRise;
          stb.latchCmd = sclkRise & lastBit;
        end
        ST_WDATA: begin
          stb.shiftIn = sclkRise;
          stb.commit  = sclkRise & lastBit;
        end
        ST_RDATA: stb.advOut = clkeSel ? sclkRise : (sclkFall & seenRise);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      seenRise <= 1'b0;
      sdoOe    <= 1'b0;
    end else if (!csActive) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      seenRise <= 1'b0;
      sdoOe    <= 1'b0;
    end else begin
      unique case (state)
        ST_CMD: if (sclkRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (lastBit) begin
            state    <= cmdRead ? ST_RDATA : ST_WDATA;
            sdoOe    <= cmdRead;
            seenRise <= 1'b0;
          end
        end
        ST_WDATA: if (sclkRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (lastBit) state <= ST_HOLD;
        end
        ST_RDATA: begin
          if (sclkRise) seenRise <= 1'b1;
          if (stb.advOut) begin
            bitCnt <= bitCnt + 3'd1;
            if (lastBit) begin
              state <= ST_HOLD;
              sdoOe <= 1'b0;
            end
          end
        end
        default: ; // ST_HOLD waits for deselect
      endcase
    end
  end
endmodule

// File: rtl/serport_dp.sv
module serport_dp
  import serport_pkg::*;
#(
  parameter int          NUM_REGS  = 32,
  parameter int          ADDR_BITS = 5,
  parameter int          SRST_ADDR = 10,
  parameter logic [7:0]  RST_BASE  = 8'h40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sdiS,
  input  strobe_t                 stb,
  output logic [7:0]              rxByte,
  output logic [NUM_REGS*8-1:0]   cfgRegs,
  output logic                    sdoData
);
  localparam logic [ADDR_BITS-1:0] RST_HIT = ADDR_BITS'(SRST_ADDR);

  logic [7:0]           shiftReg;
  logic [7:0]           outShift;
  logic [7:0]           rdVal;
  logic [ADDR_BITS-1:0] cmdAddr;
  logic [ADDR_BITS-1:0] rdAddr;
  logic                 softRst;

  assign rxByte  = {sdiS, shiftReg[7:1]};
  assign rdAddr  = rxByte[ADDR_BITS:1];
  assign softRst = stb.commit && (cmdAddr == RST_HIT);
  assign sdoData = outShift[0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] DEF = 8'(RST_BASE + g);
    logic [7:0] val;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         val <= DEF;
      else if (softRst)                                  val <= DEF;
      else if (stb.commit && cmdAddr == ADDR_BITS'(g))   val <= rxByte;
    end
    assign cfgRegs[g*8 +: 8] = val;
  end

  always_comb begin
    rdVal = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rdAddr == ADDR_BITS'(i)) rdVal = cfgRegs[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      outShift <= '0;
      cmdAddr  <= '0;
    end else if (softRst) begin
      shiftReg <= '0;
      outShift <= '0;
      cmdAddr  <= '0;
    end else begin
      if (stb.shiftIn)  shiftReg <= rxByte;
      if (stb.latchCmd) begin
        cmdAddr  <= rdAddr;
        outShift <= rdVal;
      end else if (stb.advOut) begin
        outShift <= {1'b0, outShift[7:1]};
      end
    end
  end
endmodule

// File: rtl/serial_host_port.sv
module serial_host_port
  import serport_pkg::*;
#(
  parameter int         NUM_REGS    = 32,
  parameter int         ADDR_BITS   = 5,
  parameter int         SRST_ADDR   = 10,
  parameter logic [7:0] RST_BASE    = 8'h40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  sclk,
  input  logic                  sdi,
  input  logic                  clkeSel,
  output logic                  sdoData,
  output logic                  sdoOe,
  output logic [NUM_REGS*8-1:0] cfgRegs
);
  logic    csActive, sdiS, sclkRise, sclkFall;
  logic [7:0] rxByte;
  strobe_t stb;

  serport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .csActive(csActive), .sdiS(sdiS), .sclkRise(sclkRise), .sclkFall(sclkFall)
  );

  serport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .sclkRise(sclkRise),
    .sclkFall(sclkFall), .clkeSel(clkeSel), .cmdRead(rxByte[0]),
    .stb(stb), .sdoOe(sdoOe)
  );

  serport_dp #(
    .NUM_REGS(NUM_REGS), .ADDR_BITS(ADDR_BITS),
    .SRST_ADDR(SRST_ADDR), .RST_BASE(RST_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sdiS(sdiS), .stb(stb),
    .rxByte(rxByte), .cfgRegs(cfgRegs), .sdoData(sdoData)
  );
endmodule

// File: rtl/serport_chk.sv
module serport_chk
  import serport_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  csActive,
  input logic                  sdoOe,
  input logic                  sdoData,
  input strobe_t               stb,
  input logic [NUM_REGS*8-1:0] cfgRegs
);
  // R8: a deselected port stops driving the pad on the next cycle
  assert_oe_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !sdoOe);

  // R7: no strobe reaches the datapath while deselected
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> (stb == '0));

  // R3: register contents only move after a commit strobe
  assert_reg_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRegs != $past(cfgRegs)) |-> $past(stb.commit));

  // R4/R5: read bit holds between advance strobes
  assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && $past(sdoOe) && !$past(stb.advOut)) |-> $stable(sdoData));

  // R10: no input shifting while read data is being driven
  assert_no_shift_R10: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> !stb.shiftIn);
endmodule

bind serial_host_port serport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .csActive(csActive), .sdoOe(sdoOe),
  .sdoData(sdoData), .stb(stb), .cfgRegs(cfgRegs)
);

// File: tb/sim_serial_host_port.sv
module sim_serial_host_port;
  localparam int NREG = 32;
  localparam int H    = 5;   // system cycles per SCLK half period

  logic clk = 1'b0;
  always #10 clk = ~clk;     // 50 MHz

  logic rstN, csN, sclk, sdi, clkeSel;
  wire  sdoData, sdoOe;
  wire  [NREG*8-1:0] cfgRegs;

  serial_host_port u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .clkeSel(clkeSel), .sdoData(sdoData), .sdoOe(sdoOe), .cfgRegs(cfgRegs)
  );

  int nCmp = 0, nBad = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] expQ [$];
  logic [7:0] gotByte;
  string      rdTag;
  event       rdEvt;

  function automatic logic [7:0] defVal(int i);
    return 8'(8'h40 + i);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitClk(input logic b, output logic preRise, output logic preFall, output logic oeRise);
    sclk = 1'b0; sdi = b;
    waitN(H);
    preRise = sdoData; oeRise = sdoOe;
    sclk = 1'b1;
    waitN(H);
    preFall = sdoData;
    sclk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    logic a, b, c;
    for (int i = 0; i < 8; i++) bitClk(v[i], a, b, c);
  endtask

  task automatic mdlReset();
    for (int i = 0; i < NREG; i++) mdl[i] = defVal(i);
  endtask

  task automatic checkRegs(input string tag);
    for (int i = 0; i < NREG; i++)
      chk(cfgRegs[i*8 +: 8] == mdl[i], $sformatf("%s reg%0d", tag, i), cfgRegs[i*8 +: 8], mdl[i]);
  endtask

  // Driver: write transaction, model updated per R3/R9
  task automatic writeReg(input logic [6:0] addr7, input logic [7:0] d);
    csN = 1'b0; waitN(4);
    sendByte({addr7, 1'b0});
    sendByte(d);
    waitN(H); csN = 1'b1; waitN(8);
    if (addr7[4:0] == 5'd10) mdlReset();
    else mdl[addr7[4:0]] = d;
  endtask

  // Driver: read transaction, expected byte pushed to scoreboard
  task automatic readReg(input logic [6:0] addr7, input logic clke, input string tag);
    logic [7:0] got;
    logic r, f, oe;
    clkeSel = clke;
    expQ.push_back(mdl[addr7[4:0]]);
    csN = 1'b0; waitN(4);
    chk(sdoOe == 1'b0, {tag, " R6 oe low before command"}, sdoOe, 0);
    sendByte({addr7, 1'b1});
    for (int i = 0; i < 8; i++) begin
      bitClk(1'b0, r, f, oe);
      got[i] = clke ? r : f;
      if (i == 0 || i == 7) chk(oe == 1'b1, {tag, " R6 oe during data"}, oe, 1);
    end
    waitN(H);
    chk(sdoOe == 1'b0, {tag, " R6 oe released after last bit"}, sdoOe, 0);
    csN = 1'b1; waitN(8);
    gotByte = got; rdTag = tag;
    -> rdEvt;
    waitN(2);
  endtask

  // Monitor: pops expected items and compares
  initial begin
    forever begin
      logic [7:0] e;
      @(rdEvt);
      e = expQ.pop_front();
      chk(gotByte == e, rdTag, gotByte, e);
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    logic a, b, c;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0; clkeSel = 1'b0;
    mdlReset();
    waitN(5); rstN = 1'b1; waitN(3);

    // R1 reset state
    chk(sdoOe == 1'b0, "R1 oe after reset", sdoOe, 0);
    checkRegs("R1 reset value");

    // R3 write, R4/R5 reads under both edge selects
    writeReg(7'd3, 8'hA5);
    checkRegs("R3 write reg3");
    readReg(7'd3, 1'b1, "R4 read reg3 rising");
    readReg(7'd3, 1'b0, "R5 read reg3 falling");

    // R2 upper command bits are ignored
    writeReg(7'b1100111, 8'h3C);
    checkRegs("R2 write with dont-care bits");
    readReg(7'b0100111, 1'b0, "R2 read reg7 other dont-care");

    // Boundary registers
    writeReg(7'd31, 8'h81);
    readReg(7'd31, 1'b1, "R4 read reg31");
    readReg(7'd0, 1'b0, "R5 read reg0 default");

    // R7 traffic with select high
    csN = 1'b1;
    sendByte({7'd5, 1'b0});
    sendByte(8'hFF);
    waitN(8);
    checkRegs("R7 deselected traffic");
    chk(sdoOe == 1'b0, "R7 oe while deselected", sdoOe, 0);
    readReg(7'd5, 1'b1, "R7 reg5 after deselected traffic");

    // R8 abort in the middle of a write data byte
    csN = 1'b0; waitN(4);
    sendByte({7'd5, 1'b0});
    for (int i = 0; i < 4; i++) bitClk(1'b1, a, b, c);
    csN = 1'b1; waitN(8);
    checkRegs("R8 aborted write");
    readReg(7'd5, 1'b0, "R8 reg5 after abort");

    // R8 abort in the middle of a read
    clkeSel = 1'b1;
    csN = 1'b0; waitN(4);
    sendByte({7'd3, 1'b1});
    for (int i = 0; i < 3; i++) bitClk(1'b0, a, b, c);
    chk(sdoOe == 1'b1, "R8 oe mid read", sdoOe, 1);
    csN = 1'b1; waitN(6);
    chk(sdoOe == 1'b0, "R8 oe after read abort", sdoOe, 0);

    // R10 extra clocks after a complete write
    csN = 1'b0; waitN(4);
    sendByte({7'd9, 1'b0});
    sendByte(8'h11);
    sendByte(8'hEE);
    sendByte(8'h77);
    waitN(H); csN = 1'b1; waitN(8);
    mdl[9] = 8'h11;
    checkRegs("R10 extra bits after write");

    // R10 extra clocks after a complete read keep the pad quiet
    clkeSel = 1'b1;
    csN = 1'b0; waitN(4);
    sendByte({7'd9, 1'b1});
    for (int i = 0; i < 8; i++) bitClk(1'b0, a, b, c);
    sendByte({7'd4, 1'b0});
    chk(sdoOe == 1'b0, "R10 oe after extra clocks", sdoOe, 0);
    sendByte(8'h99);
    csN = 1'b1; waitN(8);
    checkRegs("R10 extra bits after read");

    // R9 soft reset via address 10
    writeReg(7'd12, 8'hC3);
    writeReg(7'd10, 8'h5A);
    checkRegs("R9 soft reset");
    chk(sdoOe == 1'b0, "R9 oe after soft reset", sdoOe, 0);
    readReg(7'd3, 1'b1, "R9 reg3 after soft reset");
    readReg(7'd10, 1'b0, "R9 reg10 after soft reset");

    waitN(20);
    finishRun();
  end
endmodule